// File: doc/BRIEF.md
# Microsecond Free-Running Counter with Periodic Tick

This block keeps a 16-bit count that advances by one on every cycle where a one-microsecond enable is high. The count never reloads: after its all-ones value it rolls to zero and keeps going. Software times an event by reading the count when the event starts, reading it again when it ends, and subtracting the two readings. The result is in microseconds, modulo 65536.

Two interrupt sources come from the same count. The first is a tick that fires every 1024 counts (1.024 ms), whenever the low ten bits roll from 1023 to 0. The second is a wrap event, raised when the full count rolls from 0xFFFF to 0. Each source has its own enable and its own sticky pending flag, which a write-one clear strobe resets. A byte-wide read path gives a coherent 16-bit value: reading the low byte captures the upper byte into a holding register, and that register is what a later upper-byte read returns.

The reset input is active low. It clears the block at once, and its release reaches the logic only after two clock edges.

Top module: `frt_tick_timer`

## Requirements
- R1: While `rst_n` is low, `count`, both bits of `irq_pend` and the held upper byte are zero. After `rst_n` rises, the first two clock edges leave the state at zero; counting can begin on the third edge.
- R2: On each clock edge where `us_en` is 1, `count` increases by one. On each edge where `us_en` is 0, `count` keeps its value.
- R3: When `count` is 0xFFFF and `us_en` is 1, the next value of `count` is 0x0000.
- R4: `irq_pend[0]` (tick) becomes 1 after an edge where `us_en` is 1, `count[9:0]` is 1023 and `irq_en[0]` is 1.
- R5: `irq_pend[1]` (wrap) becomes 1 after an edge where `us_en` is 1, `count` is 0xFFFF and `irq_en[1]` is 1.
- R6: A tick or wrap event that occurs while the matching `irq_en` bit is 0 leaves that `irq_pend` bit unchanged.
- R7: A set `irq_pend` bit stays 1 until an edge where the matching `pend_clr` bit (bit 0 tick, bit 1 wrap) is 1. After that edge it reads 0 unless R8 applies.
- R8: When a clear strobe and an enabled event for the same source fall on the same edge, the pending bit is 1 after that edge.
- R9: An edge with `rd_en`=1 and `rd_sel`=0 copies `count[15:8]` into the held byte. While `rd_sel` is 1, `rd_data` shows the held byte, and counting does not change it.
- R10: While `rd_sel` is 0, `rd_data` shows the current `count[7:0]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| us_en | input | 1 | One-microsecond count enable |
| irq_en | input | 2 | Source enables: bit 0 tick, bit 1 wrap |
| pend_clr | input | 2 | Write-one clear strobes for the pending bits |
| rd_en | input | 1 | Read strobe; with `rd_sel`=0 it captures the upper byte |
| rd_sel | input | 1 | Byte select: 0 low byte (live), 1 held upper byte |
| rd_data | output | 8 | Selected byte |
| count | output | 16 | Live count |
| irq_pend | output | 2 | Sticky pending flags: bit 0 tick, bit 1 wrap |

## Verification
A tick or wrap event can land on the same edge as a clear strobe for that source. The clear must not lose the event. The bench counts up to exactly 0x03FF and raises both clear bits on the edge that rolls the low ten bits, then expects the tick flag to read 1. The random phase also produces such collisions at arbitrary points, and a bench model that lets the set win judges every one of them.

// File: rtl/frt_pkg.sv
package frt_pkg;
  localparam int SRC_TICK = 0;
  localparam int SRC_WRAP = 1;
  localparam int NSRC     = 2;
endpackage

// File: rtl/frt_rst_sync.sv
module frt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic s0_q, s1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0_q <= 1'b0;
      s1_q <= 1'b0;
    end else begin
      s0_q <= 1'b1;
      s1_q <= s0_q;
    end
  end

  assign rst_n_s = s1_q;
endmodule

// File: rtl/frt_count.sv
module frt_count #(
  parameter int CNT_W  = 16,
  parameter int TICK_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [CNT_W-1:0] cnt_q,
  output logic             tick_evt,
  output logic             wrap_evt
);
  localparam logic [CNT_W-1:0]  CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [TICK_W-1:0] TICK_MAX = {TICK_W{1'b1}};

  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d    = cnt_q;
    tick_evt = 1'b0;
    wrap_evt = 1'b0;
    if (step) begin
      cnt_d    = cnt_q + 1'b1;
      tick_evt = (cnt_q[TICK_W-1:0] == TICK_MAX);
      wrap_evt = (cnt_q == CNT_MAX);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (step) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/frt_flag.sv
module frt_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic en,
  input  logic clr,
  output logic flag_q
);
  logic flag_d;
  logic upd;

  always_comb begin
    upd    = clr | (evt & en);
    flag_d = (flag_q & ~clr) | (evt & en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else if (upd) flag_q <= flag_d;
  end
endmodule

// File: rtl/frt_rdport.sv
module frt_rdport #(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              rd_sel,
  input  logic [CNT_W-1:0]  cnt,
  output logic [BYTE_W-1:0] rd_data
);
  localparam int HI_W = CNT_W - BYTE_W;

  logic [HI_W-1:0] hold_q;
  logic            cap;

  always_comb begin
    cap     = rd_en & ~rd_sel;
    rd_data = rd_sel ? BYTE_W'(hold_q) : cnt[BYTE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else if (cap) hold_q <= cnt[CNT_W-1:BYTE_W];
  end
endmodule

// File: rtl/frt_tick_timer.sv
module frt_tick_timer #(
  parameter int CNT_W  = 16,
  parameter int TICK_W = 10,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              us_en,
  input  logic [1:0]        irq_en,
  input  logic [1:0]        pend_clr,
  input  logic              rd_en,
  input  logic              rd_sel,
  output logic [BYTE_W-1:0] rd_data,
  output logic [CNT_W-1:0]  count,
  output logic [1:0]        irq_pend
);
  import frt_pkg::*;

  logic             rst_n_s;
  logic [NSRC-1:0]  evt;
  logic [CNT_W-1:0] cnt_q;

  frt_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  frt_count #(.CNT_W(CNT_W), .TICK_W(TICK_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .step     (us_en),
    .cnt_q    (cnt_q),
    .tick_evt (evt[SRC_TICK]),
    .wrap_evt (evt[SRC_WRAP])
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    frt_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n_s),
      .evt    (evt[g]),
      .en     (irq_en[g]),
      .clr    (pend_clr[g]),
      .flag_q (irq_pend[g])
    );
  end

  frt_rdport #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_rd (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .rd_en   (rd_en),
    .rd_sel  (rd_sel),
    .cnt     (cnt_q),
    .rd_data (rd_data)
  );

  assign count = cnt_q;
endmodule

// File: rtl/frt_chk.sv
module frt_chk (
  input logic        clk,
  input logic        rst_n_s,
  input logic        us_en,
  input logic [1:0]  irq_en,
  input logic [1:0]  pend_clr,
  input logic        rd_en,
  input logic        rd_sel,
  input logic [7:0]  rd_data,
  input logic [15:0] count,
  input logic [1:0]  irq_pend
);
  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    us_en |=> count == 16'($past(count) + 16'd1));

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !us_en |=> $stable(count));

  // R3
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (us_en && count == 16'hFFFF) |=> count == 16'h0000);

  // R4
  tick_set_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (us_en && count[9:0] == 10'h3FF && irq_en[0]) |=> irq_pend[0]);

  // R5
  wrap_set_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (us_en && count == 16'hFFFF && irq_en[1]) |=> irq_pend[1]);

  // R6
  tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!irq_pend[0] && !irq_en[0]) |=> !irq_pend[0]);

  // R6
  wrap_gate_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!irq_pend[1] && !irq_en[1]) |=> !irq_pend[1]);

  // R7
  tick_keep_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (irq_pend[0] && !pend_clr[0]) |=> irq_pend[0]);

  // R7
  wrap_keep_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (irq_pend[1] && !pend_clr[1]) |=> irq_pend[1]);

  // R9
  hold_read_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rd_en && !rd_sel) |=> (!rd_sel || rd_data == $past(count[15:8])));

  // R10
  low_read_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !rd_sel |-> rd_data == count[7:0]);
endmodule

bind frt_tick_timer frt_chk u_chk (
  .clk      (clk),
  .rst_n_s  (rst_n_s),
  .us_en    (us_en),
  .irq_en   (irq_en),
  .pend_clr (pend_clr),
  .rd_en    (rd_en),
  .rd_sel   (rd_sel),
  .rd_data  (rd_data),
  .count    (count),
  .irq_pend (irq_pend)
);

// File: tb/sim_frt_tick_timer.sv
`timescale 1ns/1ps
module sim_frt_tick_timer;
  logic        clk;
  logic        rst_n;
  logic        us_en;
  logic [1:0]  irq_en;
  logic [1:0]  pend_clr;
  logic        rd_en;
  logic        rd_sel;
  logic [7:0]  rd_data;
  logic [15:0] count;
  logic [1:0]  irq_pend;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 0;

  // bench model state
  logic [15:0] m_cnt;
  logic [1:0]  m_pend;
  logic [7:0]  m_hold;
  logic        m_rs0, m_rs1;

  frt_tick_timer u0 (
    .clk(clk), .rst_n(rst_n), .us_en(us_en), .irq_en(irq_en),
    .pend_clr(pend_clr), .rd_en(rd_en), .rd_sel(rd_sel),
    .rd_data(rd_data), .count(count), .irq_pend(irq_pend)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic f_pend_next(logic p, logic evt, logic en, logic clr);
    return (p & ~clr) | (evt & en);
  endfunction

  function automatic logic f_tick(logic [15:0] c, logic us);
    return us && (c[9:0] == 10'h3FF);
  endfunction

  function automatic logic f_wrap(logic [15:0] c, logic us);
    return us && (c == 16'hFFFF);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = '0; m_pend = '0; m_hold = '0; m_rs0 = 0; m_rs1 = 0;
    end else begin
      if (m_rs1) begin
        m_pend[0] = f_pend_next(m_pend[0], f_tick(m_cnt, us_en), irq_en[0], pend_clr[0]);
        m_pend[1] = f_pend_next(m_pend[1], f_wrap(m_cnt, us_en), irq_en[1], pend_clr[1]);
        if (rd_en && !rd_sel) m_hold = m_cnt[15:8];
        if (us_en) m_cnt = m_cnt + 16'd1;
      end
      m_rs1 = m_rs0;
      m_rs0 = 1'b1;
    end
  end

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R2 count", count, m_cnt);
    chk("R4 tick flag", 16'(irq_pend[0]), 16'(m_pend[0]));
    chk("R5 wrap flag", 16'(irq_pend[1]), 16'(m_pend[1]));
    if (rd_sel) chk("R9 held byte", 16'(rd_data), 16'(m_hold));
    else        chk("R10 low byte", 16'(rd_data), 16'(m_cnt[7:0]));
  endtask

  task automatic cyc(logic us, logic [1:0] en, logic [1:0] clr, logic re, logic rs);
    us_en = us; irq_en = en; pend_clr = clr; rd_en = re; rd_sel = rs;
    @(negedge clk);
    compare_all();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [7:0] cap_hi;
    rst_n = 0; us_en = 1; irq_en = 2'b11; pend_clr = 0; rd_en = 0; rd_sel = 0;
    repeat (3) @(negedge clk);
    // R1: state clear under reset
    chk("R1 count in reset", count, 16'h0);
    chk("R1 pend in reset", 16'(irq_pend), 16'h0);
    chk("R1 rd_data in reset", 16'(rd_data), 16'h0);
    rst_n = 1;
    cyc(1, 2'b11, 0, 0, 0);
    cyc(1, 2'b11, 0, 0, 0);
    chk("R1 held after release", count, 16'h0);
    cyc(1, 2'b11, 0, 0, 0);
    chk("R1 first count", count, 16'h1);

    // R2: hold without enable
    repeat (5) cyc(0, 2'b11, 0, 0, 0);
    chk("R2 hold", count, 16'h1);

    // R8: tick event and clear on same edge
    while (count != 16'h03FF) cyc(1, 2'b11, 0, 0, 0);
    cyc(1, 2'b11, 2'b11, 0, 0);
    chk("R8 set beats clear", 16'(irq_pend[0]), 16'h1);
    chk("R4 count after tick", count, 16'h0400);
    // R7: sticky, then cleared
    repeat (4) cyc(1, 2'b11, 2'b10, 0, 0);
    chk("R7 sticky", 16'(irq_pend[0]), 16'h1);
    cyc(1, 2'b11, 2'b01, 0, 0);
    chk("R7 cleared", 16'(irq_pend[0]), 16'h0);

    // R6: disabled tick ignored
    while (count != 16'h0800) cyc(1, 2'b00, 0, 0, 0);
    chk("R6 tick ignored", 16'(irq_pend), 16'h0);

    // R9: coherent read
    cyc(1, 2'b11, 0, 1, 0);
    cap_hi = count[15:8];
    chk("R10 live low byte", 16'(rd_data), 16'(count[7:0]));
    repeat (300) cyc(1, 2'b11, 0, 0, 0);
    cyc(0, 2'b11, 0, 0, 1);
    chk("R9 held byte stable", 16'(rd_data), 16'(8'h08));

    // R3 and R5: full rollover
    while (count != 16'hFFFF) cyc(1, 2'b11, 2'b01, 0, 0);
    cyc(1, 2'b11, 0, 0, 0);
    chk("R3 rollover", count, 16'h0000);
    chk("R5 wrap flag set", 16'(irq_pend[1]), 16'h1);
    cyc(0, 2'b11, 2'b10, 0, 0);
    chk("R7 wrap cleared", 16'(irq_pend[1]), 16'h0);

    // random phase with a mid-run reset
    void'($urandom(32'h5eed1234));
    for (int i = 0; i < 70000; i++) begin
      if (i == 30000) begin
        rst_n = 0;
        @(negedge clk);
        chk("R1 mid-run reset", count, 16'h0);
        rst_n = 1;
      end
      cyc(($urandom % 8) != 0,
          2'(($urandom % 4 == 0) ? $urandom : 2'b11),
          2'(($urandom % 16 == 0) ? $urandom : 0),
          $urandom % 2 == 0,
          $urandom % 2 == 0);
    end
    finish_run();
  end
endmodule